// File: doc/BRIEF.md
# High-Frequency Clock Request Controller

This block serves peripheral devices that need a fast clock. A device raises a shared wired-OR request line. If software allows it, a secondary sleep-control line can also count as a request. The controller then raises an enable towards the external clock provider at once. Next it counts a programmable settling time in ticks of a 32.768 kHz time base. When that count runs out, it opens a clock gate so that the incoming fast clock reaches the output pin.

When every request has gone away, the gate closes while the fast clock is low, so no shortened pulse reaches the output. The provider enable falls only after the control side has seen that the gate is shut. A small write/read port holds three settings: the settling count, one enable bit for each request source, and a drive-strength bit for the output pad.

Top module: `hfreq_ctrl`

## Requirements
- R1: After reset the settling count (address 0) reads 328 (10 ms of 32.768 kHz ticks) and the control register (address 1) reads 1. Its bits are: bit 0 wired-OR source enable, bit 1 sleep-line source enable, bit 2 drive strength. After reset `prov_en` is 0 and `hf_clk_out` stays low.
- R2: A change on an enabled request input reaches `prov_en` on the third rising `clk` edge after the change: two synchronizer stages plus the state register. No tick is needed for this.
- R3: While the timer is settling, `hf_clk_out` stays low until the programmed number of `tick_32k` strobes has been seen in the settling state. Up to that point, one strobe fewer than the count leaves the output low.
- R4: The tick that expires the timer opens the gate. The timer reloads the programmed value, so every later request waits the full count again.
- R5: If the request drops before expiry, the controller returns to idle and `prov_en` falls. The next request again needs the full count.
- R6: Each source is masked by its own enable bit. The sleep-line source is masked after reset. A masked request leaves `prov_en` at 0 and the output low.
- R7: Writes to the settling count are clamped to the range 1..328, and reads return the stored value.
- R8: `drive_hi` follows control bit 2 (0 = low drive, 1 = high drive) and is 0 after reset.
- R9: After release, the gate shuts without a high pulse shorter than half a fast-clock period. `prov_en` stays 1 until the shut gate has been seen, and it is still 1 three `clk` edges after the release.
- R10: If a request drop and the expiring tick are seen in the same cycle, the drop wins and the gate never opens.
- R11: A write to the settling count during settling does not change the count in progress. The new value is used from the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-cycle strobe per 32.768 kHz period, in the `clk` domain |
| req_wire | input | 1 | Wired-OR clock request, asynchronous |
| req_sleep | input | 1 | Sleep-control line usable as a request, asynchronous |
| hf_clk | input | 1 | Fast clock to be gated |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data for `cfg_addr` |
| prov_en | output | 1 | Enable to the external clock provider |
| drive_hi | output | 1 | Pad drive strength select |
| hf_clk_out | output | 1 | Gated fast clock |

## Verification
Two events can land in the same control cycle: the request drop and the expiring tick. Software writes to the settling count can also coincide with an active countdown. The bench aligns the synchronized drop with the strobe that brings the count to zero. It judges the outcome from the output, which must never toggle, and from `prov_en`, which must return to 0. Separately, it rewrites the count mid-settle and checks that the gate opens after the old number of strobes.

// File: rtl/hfreq_pkg.sv
package hfreq_pkg;
  localparam int unsigned HFR_AW = 2;
  localparam logic [HFR_AW-1:0] ADDR_RELOAD = 2'd0;
  localparam logic [HFR_AW-1:0] ADDR_CTRL   = 2'd1;
  localparam int unsigned CTRL_WIRE_EN  = 0;
  localparam int unsigned CTRL_SLEEP_EN = 1;
  localparam int unsigned CTRL_DRIVE    = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_OPEN,
    ST_CLOSE
  } hfr_state_t;
endpackage

// File: rtl/hfreq_sync.sv
module hfreq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hfreq_regs.sv
module hfreq_regs
  import hfreq_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned MAX_TICKS = 328,
  localparam int unsigned CW       = $clog2(MAX_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [HFR_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [CW-1:0]     reload,
  output logic              en_wire,
  output logic              en_sleep,
  output logic              drive_hi
);
  localparam logic [DW-1:0] MAX_W = DW'(MAX_TICKS);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_TICKS);

  logic [CW-1:0] clamped;

  always_comb begin
    if (wdata == '0)        clamped = CW'(1);
    else if (wdata > MAX_W) clamped = MAX_C;
    else                    clamped = wdata[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload   <= MAX_C;
      en_wire  <= 1'b1;
      en_sleep <= 1'b0;
      drive_hi <= 1'b0;
    end else if (we) begin
      if (addr == ADDR_RELOAD) reload <= clamped;
      if (addr == ADDR_CTRL) begin
        en_wire  <= wdata[CTRL_WIRE_EN];
        en_sleep <= wdata[CTRL_SLEEP_EN];
        drive_hi <= wdata[CTRL_DRIVE];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      rdata <= '0;
      if (addr == ADDR_RELOAD) rdata <= DW'(reload);
      else if (addr == ADDR_CTRL) begin
        rdata[CTRL_WIRE_EN]  <= en_wire;
        rdata[CTRL_SLEEP_EN] <= en_sleep;
        rdata[CTRL_DRIVE]    <= drive_hi;
      end
    end
  end

  AST_RELOAD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (reload >= CW'(1)) && (reload <= MAX_C)); // R7
endmodule

// File: rtl/hfreq_fsm.sv
module hfreq_fsm
  import hfreq_pkg::*;
#(
  parameter int unsigned MAX_TICKS = 328,
  localparam int unsigned CW       = $clog2(MAX_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          req,
  input  logic          ack,
  input  logic [CW-1:0] reload,
  output logic          prov_en,
  output logic          gate_req
);
  hfr_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      prov_en  <= 1'b0;
      gate_req <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req) begin
            state   <= ST_SETTLE;
            prov_en <= 1'b1;
            cnt     <= reload;
          end
        end
        ST_SETTLE: begin
          if (!req) begin
            state   <= ST_IDLE;
            prov_en <= 1'b0;
            cnt     <= reload;
          end else if (tick) begin
            if (cnt <= CW'(1)) begin
              state    <= ST_OPEN;
              gate_req <= 1'b1;
              cnt      <= reload;
            end else begin
              cnt <= cnt - CW'(1);
            end
          end
        end
        ST_OPEN: begin
          if (!req && ack) begin
            state    <= ST_CLOSE;
            gate_req <= 1'b0;
          end
        end
        default: begin
          if (!ack) begin
            state   <= ST_IDLE;
            prov_en <= 1'b0;
          end
        end
      endcase
    end
  end

  AST_GATE_NEEDS_PROVIDER: assert property (@(posedge clk) disable iff (rst)
    ack |-> prov_en); // R3
  AST_PROV_FALL_AFTER_SHUT: assert property (@(posedge clk) disable iff (rst)
    $fell(prov_en) |-> !ack); // R9
  AST_OPEN_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_req) |-> $past(req)); // R6
  AST_DROP_WINS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE && !req) |=> !gate_req); // R10
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE && req && !tick) |=> $stable(cnt)); // R11
endmodule

// File: rtl/hfreq_gate.sv
module hfreq_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic hf_clk,
  input  logic rst,
  input  logic gate_req,
  output logic gate_on,
  output logic hf_clk_out
);
  logic en_s;
  logic en_lo;

  hfreq_sync #(.STAGES(SYNC_STAGES)) i_en_sync (
    .clk (hf_clk),
    .rst (rst),
    .d   (gate_req),
    .q   (en_s)
  );

  always_ff @(negedge hf_clk) begin
    if (rst) en_lo <= 1'b0;
    else     en_lo <= en_s;
  end

  assign gate_on    = en_lo;
  assign hf_clk_out = hf_clk & en_lo;
endmodule

// File: rtl/hfreq_ctrl.sv
module hfreq_ctrl
  import hfreq_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned MAX_TICKS   = 328,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = $clog2(MAX_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_32k,
  input  logic              req_wire,
  input  logic              req_sleep,
  input  logic              hf_clk,
  input  logic              cfg_we,
  input  logic [HFR_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              prov_en,
  output logic              drive_hi,
  output logic              hf_clk_out
);
  logic [CW-1:0] reload;
  logic          en_wire, en_sleep;
  logic          wire_s, sleep_s, ack_s;
  logic          gate_req, gate_on;
  logic          req_any;

  hfreq_regs #(.DW(DW), .MAX_TICKS(MAX_TICKS)) i_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .reload   (reload),
    .en_wire  (en_wire),
    .en_sleep (en_sleep),
    .drive_hi (drive_hi)
  );

  hfreq_sync #(.STAGES(SYNC_STAGES)) i_wire_sync (
    .clk (clk), .rst (rst), .d (req_wire), .q (wire_s)
  );
  hfreq_sync #(.STAGES(SYNC_STAGES)) i_sleep_sync (
    .clk (clk), .rst (rst), .d (req_sleep), .q (sleep_s)
  );
  hfreq_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk (clk), .rst (rst), .d (gate_on), .q (ack_s)
  );

  assign req_any = (wire_s & en_wire) | (sleep_s & en_sleep);

  hfreq_fsm #(.MAX_TICKS(MAX_TICKS)) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_32k),
    .req      (req_any),
    .ack      (ack_s),
    .reload   (reload),
    .prov_en  (prov_en),
    .gate_req (gate_req)
  );

  hfreq_gate #(.SYNC_STAGES(SYNC_STAGES)) i_gate (
    .hf_clk     (hf_clk),
    .rst        (rst),
    .gate_req   (gate_req),
    .gate_on    (gate_on),
    .hf_clk_out (hf_clk_out)
  );
endmodule

// File: tb/test_hfreq_ctrl.sv
`timescale 1ns/1ps
module test_hfreq_ctrl;
  logic clk = 1'b0, hf_clk = 1'b0, rst = 1'b1;
  logic tick_32k = 1'b0, req_wire = 1'b0, req_sleep = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic [15:0] cfg_rdata;
  logic prov_en, drive_hi, hf_clk_out;

  int checks = 0, failures = 0, edges = 0, runts = 0, base = 0;
  logic [15:0] rv;
  logic done = 1'b0;
  realtime rise_t = 0.0;

  always #10 clk = ~clk;
  always #4  hf_clk = ~hf_clk;

  hfreq_ctrl i_hfreq_ctrl (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .req_wire(req_wire),
    .req_sleep(req_sleep), .hf_clk(hf_clk), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .prov_en(prov_en), .drive_hi(drive_hi), .hf_clk_out(hf_clk_out)
  );

  always @(posedge hf_clk_out) begin
    edges++;
    rise_t = $realtime;
  end
  always @(negedge hf_clk_out) if ($realtime - rise_t < 3.9) runts++;

  // {reload[8:0], en_wire, en_sleep, drive wire, drive sleep, expect}
  localparam logic [13:0] VEC [7] = '{
    {9'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {9'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {9'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {9'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {9'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {9'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {9'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic set_req(input logic w, input logic s);
    @(negedge clk); req_wire = w; req_sleep = s;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); tick_32k = 1'b1;
    @(negedge clk); tick_32k = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    wait_cyc(10);
    base = edges;
    rst = 1'b0;
    wait_cyc(2);
    // R1 reset state
    rd(2'd0, rv); chk("R1 reload reset", rv, 328);
    rd(2'd1, rv); chk("R1 ctrl reset", rv, 1);
    chk("R1 prov_en reset", prov_en, 0);
    chk("R1 output quiet", edges - base, 0);
    chk("R8 drive reset", drive_hi, 0);

    // R2 latency, then R3/R4 with default 10 ms count
    set_req(1'b1, 1'b0);
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R2 not before third edge", prov_en, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 on third edge", prov_en, 1);
    base = edges;
    repeat (327) tick();
    wait_cyc(6);
    chk("R3 gated before full count", edges - base, 0);
    tick(); wait_cyc(6);
    chk("R4 open at full count", int'(edges > base), 1);
    set_req(1'b0, 1'b0); wait_cyc(15);
    chk("R9 provider released", prov_en, 0);

    // R7 clamping
    wr(2'd0, 16'd0);      rd(2'd0, rv); chk("R7 clamp low", rv, 1);
    wr(2'd0, 16'd1000);   rd(2'd0, rv); chk("R7 clamp high", rv, 328);
    wr(2'd0, 16'hFFFF);   rd(2'd0, rv); chk("R7 clamp max", rv, 328);
    wr(2'd0, 16'd7);      rd(2'd0, rv); chk("R7 plain", rv, 7);

    // R8 drive bit
    wr(2'd1, 16'd5); chk("R8 drive high", drive_hi, 1);
    rd(2'd1, rv); chk("R8 ctrl readback", rv, 5);
    wr(2'd1, 16'd1); chk("R8 drive low", drive_hi, 0);

    // table walk: R6 masking, R3 and R4 counts
    for (int i = 0; i < 7; i++) begin
      logic [13:0] v;
      v = VEC[i];
      wr(2'd0, {7'd0, v[13:5]});
      wr(2'd1, {14'd0, v[3], v[4]});
      set_req(v[2], v[1]);
      wait_cyc(4);
      chk($sformatf("R6 vec%0d prov_en", i), prov_en, v[0]);
      base = edges;
      repeat (int'(v[13:5]) - 1) tick();
      wait_cyc(6);
      chk($sformatf("R3 vec%0d gated", i), edges - base, 0);
      tick(); wait_cyc(6);
      chk($sformatf("R4 vec%0d opened", i), int'(edges > base), v[0]);
      set_req(1'b0, 1'b0); wait_cyc(15);
      chk($sformatf("R9 vec%0d released", i), prov_en, 0);
      base = edges; wait_cyc(5);
      chk($sformatf("R9 vec%0d shut", i), edges - base, 0);
    end
    wr(2'd1, 16'd1);

    // R5 drop before expiry
    wr(2'd0, 16'd3);
    set_req(1'b1, 1'b0); wait_cyc(4);
    tick(); tick();
    set_req(1'b0, 1'b0); wait_cyc(10);
    chk("R5 provider off after early drop", prov_en, 0);
    set_req(1'b1, 1'b0); wait_cyc(4);
    base = edges;
    tick(); tick(); wait_cyc(6);
    chk("R5 count reloaded", edges - base, 0);
    tick(); wait_cyc(6);
    chk("R5 opens after full count", int'(edges > base), 1);
    set_req(1'b0, 1'b0); wait_cyc(15);

    // R10 drop and expiry in the same cycle
    wr(2'd0, 16'd2);
    set_req(1'b1, 1'b0); wait_cyc(4);
    base = edges;
    tick();
    set_req(1'b0, 1'b0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    tick_32k = 1'b1;
    @(negedge clk); tick_32k = 1'b0;
    wait_cyc(10);
    chk("R10 gate never opened", edges - base, 0);
    chk("R10 provider off", prov_en, 0);

    // R11 write during settling
    wr(2'd0, 16'd4);
    set_req(1'b1, 1'b0); wait_cyc(4);
    base = edges;
    tick();
    wr(2'd0, 16'd10);
    tick(); tick(); wait_cyc(6);
    chk("R11 still counting old value", edges - base, 0);
    tick(); wait_cyc(6);
    chk("R11 opens on old count", int'(edges > base), 1);
    set_req(1'b0, 1'b0);
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R9 provider held while shutting", prov_en, 1);
    wait_cyc(15);
    chk("R9 provider off after shut", prov_en, 0);
    chk("R9 output low", hf_clk_out, 0);
    rd(2'd0, rv); chk("R11 new value stored", rv, 10);
    chk("R9 no runt pulses", runts, 0);
    finish_run();
  end
endmodule